// File: doc/BRIEF.md
# Ratio-Table Bus Clock Divider Bank

This block turns one fast reference clock into three clock-enable streams: a core enable, a bus enable and a peripheral enable. Each ratio comes from a 3-bit or 2-bit code in a 32-bit configuration word. A fixed lookup table maps each code to a divisor, and the table is irregular. The bus table contains ratios of 5 and 6, and several core codes are aliases that all mean divide by 1.

The core and bus dividers count reference cycles. The peripheral divider counts bus-enable pulses, so every peripheral pulse coincides with a bus pulse. Logic downstream of the block runs on the reference clock and qualifies its registers with these single-cycle enables.

Software places a new word on the configuration input and pulses a load strobe. Each divider keeps its current ratio until its own pulse completes, then switches. This prevents any truncated interval.

The block drives the divisors that are currently in force as plain numbers, so the pulse spacing can be compared against them.

Top module: `clk_ratio_bank`

## Requirements
- R1: The core divisor is decoded from word bits [27:25]. Codes 0, 1, 2, 3, 4 give 1, 2, 4, 8, 16, and codes 5, 6, 7 give 1.
- R2: The bus divisor is decoded from word bits [22:20]. Codes 0 to 7 give 1, 2, 4, 5, 6, 8, 16, 32 in that order.
- R3: The peripheral divisor is decoded from word bits [19:18]. Codes 0 to 3 give 1, 2, 4, 8.
- R4: `per_en` is high only in cycles where `bus_en` is high. With peripheral divisor P and bus divisor B, `per_en` pulses every P*B reference cycles.
- R5: With divisor 1, the enable is high on every reference cycle. With divisor N greater than 1, it is high for exactly one cycle in every N.
- R6: `cfg_word` is captured only in a cycle where `cfg_load` is high. Changes to `cfg_word` without the strobe leave the divisor outputs and the enables unchanged.
- R7: A divisor output changes only in the cycle right after a pulse of its own enable. The interval that starts after that pulse uses the new divisor, so no interval is shorter than either the old or the new ratio.
- R8: After reset, all three divisor outputs read 1 and all three enables are high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures `cfg_word` |
| cfg_word | input | 32 | Configuration word holding the three ratio codes |
| core_en | output | 1 | Core clock enable |
| bus_en | output | 1 | Bus clock enable |
| per_en | output | 1 | Peripheral clock enable, a subset of `bus_en` |
| core_div | output | 5 | Core divisor currently in force |
| bus_div | output | 6 | Bus divisor currently in force |
| per_div | output | 4 | Peripheral divisor currently in force |

## Verification
Random configuration words cover the codes of all three tables together. The directed words target the aliased core codes and the bus ratios of 5 and 6. These directed cases separate a correct table from a power-of-two shortcut.

A running monitor compares every gap between pulses with the divisor in force right after the earlier pulse. This check tells an immediate switch apart from a switch held back to the terminal count.

The peripheral spacing is measured in reference cycles under large bus ratios. This exposes a peripheral counter that counts reference cycles instead of bus pulses.

Finally, a word is changed without the strobe to confirm that nothing moves.

// File: rtl/clk_ratio_bank.sv
module clk_ratio_bank #(
  parameter int CORE_W = 5,
  parameter int BUS_W  = 6,
  parameter int PER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [31:0]       cfg_word,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en,
  output logic [CORE_W-1:0] core_div,
  output logic [BUS_W-1:0]  bus_div,
  output logic [PER_W-1:0]  per_div
);

  localparam int CORE_LSB = 25;
  localparam int BUS_LSB  = 20;
  localparam int PER_LSB  = 18;

  function automatic logic [CORE_W-1:0] core_lut(input logic [2:0] c);
    case (c)
      3'd1:    core_lut = CORE_W'(2);
      3'd2:    core_lut = CORE_W'(4);
      3'd3:    core_lut = CORE_W'(8);
      3'd4:    core_lut = CORE_W'(16);
      default: core_lut = CORE_W'(1);
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] bus_lut(input logic [2:0] c);
    case (c)
      3'd0: bus_lut = BUS_W'(1);
      3'd1: bus_lut = BUS_W'(2);
      3'd2: bus_lut = BUS_W'(4);
      3'd3: bus_lut = BUS_W'(5);
      3'd4: bus_lut = BUS_W'(6);
      3'd5: bus_lut = BUS_W'(8);
      3'd6: bus_lut = BUS_W'(16);
      default: bus_lut = BUS_W'(32);
    endcase
  endfunction

  function automatic logic [PER_W-1:0] per_lut(input logic [1:0] c);
    per_lut = PER_W'(1) << c;
  endfunction

  logic [CORE_W-1:0] core_pend, core_cnt;
  logic [BUS_W-1:0]  bus_pend, bus_cnt;
  logic [PER_W-1:0]  per_pend, per_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_pend <= CORE_W'(1);
      bus_pend  <= BUS_W'(1);
      per_pend  <= PER_W'(1);
    end else if (cfg_load) begin
      core_pend <= core_lut(cfg_word[CORE_LSB +: 3]);
      bus_pend  <= bus_lut(cfg_word[BUS_LSB +: 3]);
      per_pend  <= per_lut(cfg_word[PER_LSB +: 2]);
    end
  end

  assign core_en = (core_cnt == core_div - CORE_W'(1));
  assign bus_en  = (bus_cnt == bus_div - BUS_W'(1));
  assign per_en  = bus_en && (per_cnt == per_div - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_cnt <= '0;
      core_div <= CORE_W'(1);
    end else if (core_en) begin
      core_cnt <= '0;
      core_div <= core_pend;
    end else begin
      core_cnt <= core_cnt + CORE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cnt <= '0;
      bus_div <= BUS_W'(1);
    end else if (bus_en) begin
      bus_cnt <= '0;
      bus_div <= bus_pend;
    end else begin
      bus_cnt <= bus_cnt + BUS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      per_div <= PER_W'(1);
    end else if (per_en) begin
      per_cnt <= '0;
      per_div <= per_pend;
    end else if (bus_en) begin
      per_cnt <= per_cnt + PER_W'(1);
    end
  end

  assert_per_in_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en);

  assert_core_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_cnt < core_div);

  assert_bus_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cnt < bus_div);

  assert_core_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_div) |-> $past(core_en));

  assert_bus_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_div) |-> $past(bus_en));

  assert_per_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_div) |-> $past(per_en));

  assert_per_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(per_cnt));

endmodule

// File: tb/clk_ratio_bank_tb_top.sv
module clk_ratio_bank_tb_top;
  logic clk = 0, rst_n = 0, cfg_load = 0;
  logic [31:0] cfg_word = '0;
  logic core_en, bus_en, per_en;
  logic [4:0] core_div;
  logic [5:0] bus_div;
  logic [3:0] per_div;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  clk_ratio_bank dut_i (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .core_en(core_en), .bus_en(bus_en), .per_en(per_en),
    .core_div(core_div), .bus_div(bus_div), .per_div(per_div));

  function automatic int exp_core(input logic [31:0] w);
    case (w[27:25]) 1: return 2; 2: return 4; 3: return 8; 4: return 16; default: return 1; endcase
  endfunction
  function automatic int exp_bus(input logic [31:0] w);
    case (w[22:20]) 0: return 1; 1: return 2; 2: return 4; 3: return 5;
      4: return 6; 5: return 8; 6: return 16; default: return 32; endcase
  endfunction
  function automatic int exp_per(input logic [31:0] w);
    return 1 << w[19:18];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // running monitors for R5/R7 (spacing) and R4 (subset)
  int cyc = 0;
  int c_last, b_last, c_exp, b_exp;
  bit c_valid, b_valid, c_arm, b_arm, p_en_d, c_en_d, b_en_d;
  logic [4:0] c_div_d; logic [5:0] b_div_d; logic [3:0] p_div_d;
  always @(negedge clk) begin
    if (!rst_n) begin
      c_valid = 0; b_valid = 0; c_arm = 0; b_arm = 0;
      c_en_d = 0; b_en_d = 0; p_en_d = 0;
      c_div_d = 1; b_div_d = 1; p_div_d = 1;
    end else begin
      cyc++;
      if (c_arm) begin c_exp = core_div; c_arm = 0; end
      if (b_arm) begin b_exp = bus_div; b_arm = 0; end
      if (core_en) begin
        if (c_valid) check("R5 core gap", cyc - c_last, c_exp);
        c_last = cyc; c_valid = 1; c_arm = 1;
      end
      if (bus_en) begin
        if (b_valid) check("R5 bus gap", cyc - b_last, b_exp);
        b_last = cyc; b_valid = 1; b_arm = 1;
      end
      if (per_en && !bus_en) check("R4 per without bus", 1, 0);
      if (core_div != c_div_d) check("R7 core switch after pulse", c_en_d, 1);
      if (bus_div != b_div_d) check("R7 bus switch after pulse", b_en_d, 1);
      if (per_div != p_div_d) check("R7 per switch after pulse", p_en_d, 1);
      c_en_d = core_en; b_en_d = bus_en; p_en_d = per_en;
      c_div_d = core_div; b_div_d = bus_div; p_div_d = per_div;
    end
  end

  task automatic load(input logic [31:0] w);
    @(negedge clk); cfg_word = w; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic per_gap(output int gap);
    int n = 0;
    gap = -1;
    while (!per_en && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); gap = 1;
    while (!per_en && gap < 2000) begin @(negedge clk); gap++; end
  endtask

  task automatic run_word(input logic [31:0] w);
    int g;
    load(w);
    repeat (600) @(negedge clk);
    check("R1 core divisor", core_div, exp_core(w));
    check("R2 bus divisor", bus_div, exp_bus(w));
    check("R3 per divisor", per_div, exp_per(w));
    per_gap(g);
    check("R4 per spacing", g, exp_per(w) * exp_bus(w));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 core_div", core_div, 1);
    check("R8 bus_div", bus_div, 1);
    check("R8 per_div", per_div, 1);
    check("R8 enables", {core_en, bus_en, per_en}, 3'b111);
    rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      check("R8 enables held", {core_en, bus_en, per_en}, 3'b111);
    end
    // directed: aliased core codes and bus 5/6
    run_word({4'h0, 3'd5, 2'b0, 3'd3, 2'd2, 18'h0});
    run_word({4'h0, 3'd6, 2'b0, 3'd4, 2'd3, 18'h0});
    run_word({4'h0, 3'd7, 2'b0, 3'd7, 2'd1, 18'h0});
    run_word({4'h0, 3'd4, 2'b0, 3'd0, 2'd0, 18'h0});
    // R6: change word without load
    begin
      logic [31:0] held = {4'h0, 3'd2, 2'b0, 3'd1, 2'd1, 18'h0};
      run_word(held);
      @(negedge clk); cfg_word = {4'h0, 3'd4, 2'b0, 3'd7, 2'd3, 18'h0};
      repeat (600) @(negedge clk);
      check("R6 core unchanged", core_div, exp_core(held));
      check("R6 bus unchanged", bus_div, exp_bus(held));
      check("R6 per unchanged", per_div, exp_per(held));
    end
    for (int i = 0; i < 14; i++) run_word($urandom);
    // R5 divisor 1 everywhere
    load(32'h0);
    repeat (600) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check("R5 div1 high", {core_en, bus_en, per_en}, 3'b111);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule